// File: doc/BRIEF.md
# Multiply-Divide Unit with Read Interlock

This block performs 32-bit multiplication and division on behalf of an integer core. Results go into two holding registers, HI and LO. A command port accepts signed or unsigned multiply, signed or unsigned divide, and direct loads of HI or LO. A read port returns one of the two registers.

Each multiply or divide opens a busy window. The length of the window models the unit's real latency. Divides always take a fixed window. Multiplies take a shorter window when the first operand is small in magnitude. A read raised while the window is open is held off, and it completes on the first cycle after the window closes.

Division uses a restoring shift-subtract loop that runs one bit per cycle on operand magnitudes, and the signs are corrected at the end. Division by zero and the most-negative-by-minus-one overflow both yield fixed results without any trap.

Top module: `muldiv_interlock`

## Requirements
- R1: After reset, HI and LO hold 0 and `busy` is low, so a read completes at once with value 0.
- R2: Command code 0 (signed multiply) sign-extends both operands and forms a 64-bit product. The upper 32 bits go to HI and the lower 32 bits go to LO.
- R3: Command code 1 (unsigned multiply) zero-extends both operands and splits the 64-bit product the same way as R2.
- R4: For unsigned multiply, let s = `cmd_a`. The busy window is 15 cycles if any of bits 31..21 of s is set. Otherwise it is 11 cycles if any of bits 20..10 is set. Otherwise it is 7 cycles.
- R5: For signed multiply, s is `cmd_a` XOR (`cmd_a` shifted arithmetically right by 21), and the window then follows the R4 rule.
- R6: Command codes 2 (signed divide) and 3 (unsigned divide) open a 37-cycle busy window. The quotient goes to LO and the remainder goes to HI. A signed quotient truncates toward zero, and a signed remainder takes the dividend's sign.
- R7: A signed divide by zero gives HI = dividend. LO is 0xFFFFFFFF for a non-negative dividend and 1 for a negative dividend.
- R8: A signed divide of 0x80000000 by 0xFFFFFFFF gives LO = 0x80000000 and HI = 0.
- R9: An unsigned divide by zero gives LO = 0xFFFFFFFF and HI = dividend.
- R10: `rd_valid` stays low while `busy` is high, even with `rd_req` held. When the window closes, the read returns the new result. `rd_sel` = 1 selects HI and `rd_sel` = 0 selects LO.
- R11: Command codes 4 and 5 load `cmd_a` into HI and LO respectively, visible on the next cycle. They do not open a busy window.
- R12: A multiply or divide issued while busy replaces the pending operation. It restarts the window with its own length, and the replaced result never lands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Command code (0 smul, 1 umul, 2 sdiv, 3 udiv, 4 load HI, 5 load LO) |
| cmd_a | input | 32 | First operand, dividend, or load value |
| cmd_b | input | 32 | Second operand or divisor |
| rd_req | input | 1 | Read request, held until served |
| rd_sel | input | 1 | 1 selects HI, 0 selects LO |
| rd_valid | output | 1 | Read served this cycle |
| rd_data | output | 32 | Selected register value |
| busy | output | 1 | Busy window open |

## Verification
A command is taken at one rising edge, and `busy` is high from that edge for exactly as many cycles as the latency rule gives. The bench therefore counts `busy` at each falling edge after issue and compares the count with 7, 11, 15 or 37. The read port is combinational, so HI and LO are sampled shortly after a falling edge once the count ends. For the stall case, `rd_req` is raised in the cycle after issue, and the bench counts cycles until `rd_valid` appears. Loads of HI or LO are read back on the falling edge that follows the capturing rising edge.

// File: rtl/muldiv_interlock.sv
module muldiv_interlock #(
  parameter int DIV_CYCLES = 37
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd_op,
  input  logic [31:0] cmd_a,
  input  logic [31:0] cmd_b,
  input  logic        rd_req,
  input  logic        rd_sel,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  output logic        busy
);
  localparam int CW = $clog2(DIV_CYCLES + 1);

  logic [31:0] hi_q, lo_q, rem_q, quo_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic [5:0] step_q;
  logic neg_quo_q, neg_rem_q;

  wire is_signed = ~cmd_op[0];
  wire [31:0] sra21 = 32'($signed(cmd_a) >>> 21);
  wire [31:0] size_src = is_signed ? (cmd_a ^ sra21) : cmd_a;
  wire [CW-1:0] mul_lat = (size_src[31:21] != 0) ? CW'(15) :
                          (size_src[20:10] != 0) ? CW'(11) : CW'(7);
  wire [63:0] ext_a = {{32{is_signed & cmd_a[31]}}, cmd_a};
  wire [63:0] ext_b = {{32{is_signed & cmd_b[31]}}, cmd_b};
  wire [63:0] prod  = ext_a * ext_b;

  wire [31:0] mag_a = (is_signed && cmd_a[31]) ? -cmd_a : cmd_a;
  wire [31:0] mag_b = (is_signed && cmd_b[31]) ? -cmd_b : cmd_b;

  wire [32:0] shl   = {rem_q, quo_q[31]};
  wire        take  = shl >= {1'b0, dvs_q};
  wire [31:0] sub   = shl[31:0] - dvs_q;
  wire [31:0] rem_n = take ? sub : shl[31:0];
  wire [31:0] quo_n = {quo_q[30:0], take};

  assign busy     = cnt_q != 0;
  assign rd_valid = rd_req & ~busy;
  assign rd_data  = rd_sel ? hi_q : lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0; lo_q <= '0; rem_q <= '0; quo_q <= '0; dvs_q <= '0;
      cnt_q <= '0; step_q <= '0; neg_quo_q <= 1'b0; neg_rem_q <= 1'b0;
    end else begin
      if (busy) cnt_q <= cnt_q - 1'b1;
      if (step_q != 0) begin
        rem_q  <= rem_n;
        quo_q  <= quo_n;
        step_q <= step_q - 1'b1;
        if (step_q == 6'd1) begin
          lo_q <= neg_quo_q ? -quo_n : quo_n;
          hi_q <= neg_rem_q ? -rem_n : rem_n;
        end
      end
      if (cmd_valid) begin
        case (cmd_op)
          3'd0, 3'd1: begin
            hi_q   <= prod[63:32];
            lo_q   <= prod[31:0];
            cnt_q  <= mul_lat;
            step_q <= '0;
          end
          3'd2, 3'd3: begin
            rem_q     <= '0;
            quo_q     <= mag_a;
            dvs_q     <= mag_b;
            neg_quo_q <= is_signed & (cmd_a[31] ^ cmd_b[31]);
            neg_rem_q <= is_signed & cmd_a[31];
            step_q    <= 6'd32;
            cnt_q     <= CW'(DIV_CYCLES);
          end
          3'd4: hi_q <= cmd_a;
          3'd5: lo_q <= cmd_a;
          default: ;
        endcase
      end
    end
  end

  assert_div_lands_before_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> step_q == 0);
  assert_mul_opens_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op[2:1] == 2'b00) |=> busy);
  assert_load_lo_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd5) |=> lo_q == $past(cmd_a));
  assert_hold_while_waiting_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cmd_valid && step_q == 0) |=> ($stable(hi_q) && $stable(lo_q)));
  assert_countdown_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cmd_valid) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: tb/muldiv_interlock_tb.sv
module muldiv_interlock_tb;
  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, rd_req = 0, rd_sel = 0;
  logic [2:0] cmd_op = 0;
  logic [31:0] cmd_a = 0, cmd_b = 0;
  logic rd_valid, busy;
  logic [31:0] rd_data;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  muldiv_interlock u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_a(cmd_a), .cmd_b(cmd_b), .rd_req(rd_req), .rd_sel(rd_sel),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy)
  );

  localparam int NV = 16;
  localparam logic [2:0] V_OP [NV] = '{0, 0, 1, 1, 1, 1, 0, 0, 2, 2, 3, 2, 2, 2, 3, 2};
  localparam logic [31:0] V_A [NV] = '{
    32'd3, 32'hFFFFFFFE, 32'hFFFFFFFE, 32'h00100000, 32'h000003FF, 32'h00000400,
    32'h12345678, 32'hFFF00000, 32'd100, 32'hFFFFFF9C, 32'hFFFFFFFF, 32'd100,
    32'hFFFFFFFB, 32'h80000000, 32'h80000005, 32'd7};
  localparam logic [31:0] V_B [NV] = '{
    32'd5, 32'd3, 32'd3, 32'h10, 32'd2, 32'd1, 32'h100, 32'd1, 32'd7, 32'd7,
    32'h10, 32'd0, 32'd0, 32'hFFFFFFFF, 32'd0, 32'hFFFFFFFE};
  localparam logic [31:0] V_HI [NV] = '{
    32'd0, 32'hFFFFFFFF, 32'd2, 32'd0, 32'd0, 32'd0, 32'h12, 32'hFFFFFFFF,
    32'd2, 32'hFFFFFFFE, 32'hF, 32'd100, 32'hFFFFFFFB, 32'd0, 32'h80000005, 32'd1};
  localparam logic [31:0] V_LO [NV] = '{
    32'd15, 32'hFFFFFFFA, 32'hFFFFFFFA, 32'h01000000, 32'h7FE, 32'h400,
    32'h34567800, 32'hFFF00000, 32'd14, 32'hFFFFFFF2, 32'h0FFFFFFF, 32'hFFFFFFFF,
    32'd1, 32'h80000000, 32'hFFFFFFFF, 32'hFFFFFFFD};
  localparam int V_LAT [NV] = '{7, 7, 15, 11, 7, 11, 15, 11, 37, 37, 37, 37, 37, 37, 37, 37};
  localparam string V_REQ [NV] = '{"R2/R5", "R2/R5", "R3/R4", "R3/R4", "R3/R4", "R3/R4",
    "R2/R5", "R2/R5", "R6", "R6", "R6", "R7", "R7", "R8", "R9", "R6"};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_a = a; cmd_b = b;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    #1;
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic read_reg(input logic sel, output logic [31:0] d, output logic v);
    rd_req = 1; rd_sel = sel;
    #1;
    d = rd_data; v = rd_valid;
    rd_req = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    logic [31:0] d;
    logic v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy), 0);
    read_reg(1, d, v); chk("R1 HI", d, 0); chk("R1 valid", 32'(v), 1);
    read_reg(0, d, v); chk("R1 LO", d, 0);

    for (int i = 0; i < NV; i++) begin
      issue(V_OP[i], V_A[i], V_B[i]);
      count_busy(n);
      chk({V_REQ[i], " latency"}, 32'(n), 32'(V_LAT[i]));
      read_reg(1, d, v); chk({V_REQ[i], " HI"}, d, V_HI[i]);
      read_reg(0, d, v); chk({V_REQ[i], " LO"}, d, V_LO[i]);
    end

    // R10 read stall with rd_req held from the cycle after issue
    issue(3'd2, 32'd1000, 32'd3);
    rd_req = 1; rd_sel = 0;
    n = 0;
    #1;
    while (!rd_valid && n < 100) begin
      n++;
      @(negedge clk);
      #1;
    end
    chk("R10 stall cycles", 32'(n), 37);
    chk("R10 data", rd_data, 32'd333);
    rd_req = 0;

    // R11 direct loads
    issue(3'd4, 32'hCAFE0001, 32'd0);
    #1; chk("R11 no window HI", 32'(busy), 0);
    read_reg(1, d, v); chk("R11 HI", d, 32'hCAFE0001);
    issue(3'd5, 32'h00001234, 32'd0);
    read_reg(0, d, v); chk("R11 LO", d, 32'h00001234);
    read_reg(1, d, v); chk("R11 HI kept", d, 32'hCAFE0001);

    // R12 multiply replaces a pending divide
    issue(3'd3, 32'd100, 32'd7);
    repeat (4) @(negedge clk);
    issue(3'd1, 32'd2, 32'd3);
    count_busy(n);
    chk("R12 restart latency", 32'(n), 7);
    repeat (40) @(negedge clk);
    read_reg(0, d, v); chk("R12 LO not overwritten", d, 32'd6);
    read_reg(1, d, v); chk("R12 HI not overwritten", d, 32'd0);

    // R12 divide replaces a divide and restarts the full window
    issue(3'd3, 32'd50, 32'd5);
    repeat (9) @(negedge clk);
    issue(3'd3, 32'd81, 32'd4);
    count_busy(n);
    chk("R12 divide restart", 32'(n), 37);
    read_reg(0, d, v); chk("R12 quotient", d, 32'd20);
    read_reg(1, d, v); chk("R12 remainder", d, 32'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule